// File: doc/BRIEF.md
# USB Buffer Descriptor Fetch Engine

This block sits on the serial-engine side of a USB endpoint buffer manager. Each endpoint direction has a four-byte descriptor in a table held in shared RAM. The descriptor is laid out as follows:

- offset 0: status
- offset 1: byte count
- offset 2: buffer address, low byte
- offset 3: buffer address, high byte

Bit 7 of the status byte is an ownership semaphore. When it is 0 the CPU owns the descriptor. When it is 1 the engine owns it.

When a transaction request arrives naming an endpoint and a direction, the engine first checks the endpoint's enable bit. It then reads the descriptor one byte per cycle through a single-port RAM port with one cycle of read latency. If the engine owns the descriptor, it hands the buffer address, byte count and status to a data mover. If the endpoint is disabled or the descriptor is not owned, it answers with a NAK.

When the data mover reports completion, the engine writes the transferred count back first. It then writes the status byte with the ownership bit cleared, which hands the descriptor back to the CPU.

Top module: `bd_engine`

## Requirements
- R1: After reset, busy_o, fetch_ok_o, fetch_nak_o, wb_done_o and mem_req_o are all 0.
- R2: The descriptor for endpoint e and direction d (OUT=0, IN=1) starts at 0x400 + 4*(2*e+d). A fetch reads offsets 0, 1, 2 and 3 in that order, one read per cycle. Offset 0 is status, 1 is count, 2 is address low and 3 is address high.
- R3: A request accepted for an endpoint whose ep_en_i bit is 0 raises fetch_nak_o in the cycle after the request cycle. It makes no RAM access.
- R4: For an enabled endpoint whose status bit 7 is 0, fetch_nak_o is raised in the sixth cycle after the request cycle. No RAM write follows, and the engine returns to idle.
- R5: For an enabled endpoint whose status bit 7 is 1, fetch_ok_o is raised in the sixth cycle after the request cycle. At the same time, buf_addr_o = {address high, address low}, buf_cnt_o = count and buf_stat_o = status.
- R6: After xfer_done_i, the engine makes exactly two RAM writes. The first writes xfer_cnt_i to offset 1. The second writes {0, xfer_stat_i} to offset 0. wb_done_o is raised in the cycle after the second write.
- R7: A request presented while busy_o is 1 is ignored: it causes no RAM access and no fetch_ok_o or fetch_nak_o.
- R8: fetch_ok_o, fetch_nak_o and wb_done_o are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ep_en_i | input | NUM_EP | Per-endpoint enable bits |
| req_valid_i | input | 1 | Transaction request, sampled while idle |
| req_ep_i | input | log2(NUM_EP) | Requested endpoint number |
| req_dir_i | input | 1 | Direction: 0 OUT, 1 IN |
| busy_o | output | 1 | Engine is not idle |
| fetch_ok_o | output | 1 | Descriptor owned by the engine; buffer fields are valid |
| fetch_nak_o | output | 1 | Endpoint disabled or descriptor owned by the CPU |
| buf_addr_o | output | 16 | Buffer address from the descriptor |
| buf_cnt_o | output | 8 | Byte count from the descriptor |
| buf_stat_o | output | 8 | Status byte from the descriptor |
| xfer_done_i | input | 1 | Data mover has finished the transfer |
| xfer_cnt_i | input | 8 | Number of bytes actually transferred |
| xfer_stat_i | input | 7 | Status bits 6:0 to write back |
| wb_done_o | output | 1 | Write-back complete; descriptor returned to the CPU |
| mem_req_o | output | 1 | RAM access this cycle |
| mem_we_o | output | 1 | RAM write enable |
| mem_addr_o | output | ADDR_W | RAM byte address |
| mem_wdata_o | output | 8 | RAM write data |
| mem_rdata_i | input | 8 | RAM read data, one cycle after the read |

## Verification
The bench targets the table edges: endpoint 0 OUT at the table base and endpoint 15 IN at the last slot. An index built with the direction in the wrong bit, or with a wrong stride, reads a neighbouring descriptor and returns the wrong buffer fields.

Disabled endpoints and CPU-owned descriptors are mixed at random. A design that skips the enable check would touch plain RAM. A design that acts on a descriptor it does not own would grant it or write it back.

The order of the write-back is logged from the RAM port. Swapping the two writes would release ownership before the count is valid, and failing to clear bit 7 would leave the descriptor stuck with the engine.

A request arriving in the middle of a transfer checks that a busy engine does not begin a second fetch.

// File: rtl/bd_pkg.sv
package bd_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_CHECK,
    ST_XFER,
    ST_WB_CNT,
    ST_WB_STAT
  } bd_state_e;

  localparam logic [1:0] OFF_STAT = 2'd0;
  localparam logic [1:0] OFF_CNT  = 2'd1;
  localparam logic [1:0] OFF_LAST = 2'd3;
  localparam int         OWN_BIT  = 7;
endpackage

// File: rtl/bd_addr_calc.sv
module bd_addr_calc #(
  parameter int ADDR_W   = 16,
  parameter int EP_W     = 4,
  parameter int BDT_BASE = 'h400
) (
  input  logic [EP_W-1:0]   ep_i,
  input  logic              dir_i,
  input  logic [1:0]        off_i,
  output logic [ADDR_W-1:0] addr_o
);
  localparam int OFS_W = EP_W + 3;

  // index = ep*2 + dir, four bytes per descriptor
  logic [OFS_W-1:0] ofs;
  assign ofs    = {ep_i, dir_i, off_i};
  assign addr_o = ADDR_W'(BDT_BASE) + ADDR_W'(ofs);
endmodule

// File: rtl/bd_field_cap.sv
module bd_field_cap (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        cap_i,
  input  logic [1:0]  off_i,
  input  logic [7:0]  byte_i,
  output logic [7:0]  stat_o,
  output logic [7:0]  cnt_o,
  output logic [15:0] addr_o
);
  logic [7:0] byte_q [4];

  for (genvar g = 0; g < 4; g++) begin : g_byte
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             byte_q[g] <= '0;
      else if (cap_i && off_i == 2'(g))        byte_q[g] <= byte_i;
    end
  end

  assign stat_o = byte_q[0];
  assign cnt_o  = byte_q[1];
  assign addr_o = {byte_q[3], byte_q[2]};

  // R2: bytes arrive in offset order, back to back
  a_r2_capture_order: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_i && off_i != 2'd0) |-> ($past(cap_i) && off_i == $past(off_i) + 2'd1));
endmodule

// File: rtl/bd_engine.sv
module bd_engine #(
  parameter int NUM_EP   = 16,
  parameter int ADDR_W   = 16,
  parameter int BDT_BASE = 'h400,
  localparam int EP_W    = $clog2(NUM_EP)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_EP-1:0] ep_en_i,
  input  logic              req_valid_i,
  input  logic [EP_W-1:0]   req_ep_i,
  input  logic              req_dir_i,
  output logic              busy_o,
  output logic              fetch_ok_o,
  output logic              fetch_nak_o,
  output logic [15:0]       buf_addr_o,
  output logic [7:0]        buf_cnt_o,
  output logic [7:0]        buf_stat_o,
  input  logic              xfer_done_i,
  input  logic [7:0]        xfer_cnt_i,
  input  logic [6:0]        xfer_stat_i,
  output logic              wb_done_o,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [7:0]        mem_wdata_o,
  input  logic [7:0]        mem_rdata_i
);
  import bd_pkg::*;

  bd_state_e       state_q;
  logic [EP_W-1:0] ep_q;
  logic            dir_q;
  logic [1:0]      off_q, off_mux, rd_off_q;
  logic            rd_vld_q;
  logic [7:0]      wcnt_q;
  logic [6:0]      wstat_q;
  logic            ok_q, nak_q, wb_q;
  logic [ADDR_W-1:0] base_addr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      ep_q     <= '0;
      dir_q    <= 1'b0;
      off_q    <= '0;
      rd_vld_q <= 1'b0;
      rd_off_q <= '0;
      wcnt_q   <= '0;
      wstat_q  <= '0;
      ok_q     <= 1'b0;
      nak_q    <= 1'b0;
      wb_q     <= 1'b0;
    end else begin
      ok_q     <= 1'b0;
      nak_q    <= 1'b0;
      wb_q     <= 1'b0;
      rd_vld_q <= (state_q == ST_FETCH);
      rd_off_q <= off_q;
      unique case (state_q)
        ST_IDLE: if (req_valid_i) begin
          ep_q  <= req_ep_i;
          dir_q <= req_dir_i;
          off_q <= OFF_STAT;
          if (ep_en_i[req_ep_i]) state_q <= ST_FETCH;
          else                   nak_q   <= 1'b1;
        end
        ST_FETCH: begin
          off_q <= off_q + 2'd1;
          if (off_q == OFF_LAST) state_q <= ST_CHECK;
        end
        ST_CHECK: begin
          // last byte lands this edge; status was captured three edges ago
          if (buf_stat_o[OWN_BIT]) begin
            ok_q    <= 1'b1;
            state_q <= ST_XFER;
          end else begin
            nak_q   <= 1'b1;
            state_q <= ST_IDLE;
          end
        end
        ST_XFER: if (xfer_done_i) begin
          wcnt_q  <= xfer_cnt_i;
          wstat_q <= xfer_stat_i;
          state_q <= ST_WB_CNT;
        end
        ST_WB_CNT:  state_q <= ST_WB_STAT;
        ST_WB_STAT: begin
          wb_q    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    unique case (state_q)
      ST_WB_CNT:  off_mux = OFF_CNT;
      ST_WB_STAT: off_mux = OFF_STAT;
      default:    off_mux = off_q;
    endcase
  end

  bd_addr_calc #(.ADDR_W(ADDR_W), .EP_W(EP_W), .BDT_BASE(BDT_BASE)) u_addr (
    .ep_i(ep_q), .dir_i(dir_q), .off_i(off_mux), .addr_o(mem_addr_o)
  );

  bd_addr_calc #(.ADDR_W(ADDR_W), .EP_W(EP_W), .BDT_BASE(BDT_BASE)) u_base (
    .ep_i(ep_q), .dir_i(dir_q), .off_i(OFF_STAT), .addr_o(base_addr)
  );

  bd_field_cap u_fields (
    .clk_i(clk_i), .rst_ni(rst_ni), .cap_i(rd_vld_q), .off_i(rd_off_q),
    .byte_i(mem_rdata_i), .stat_o(buf_stat_o), .cnt_o(buf_cnt_o), .addr_o(buf_addr_o)
  );

  assign mem_req_o   = (state_q == ST_FETCH) || (state_q == ST_WB_CNT) || (state_q == ST_WB_STAT);
  assign mem_we_o    = (state_q == ST_WB_CNT) || (state_q == ST_WB_STAT);
  assign mem_wdata_o = (state_q == ST_WB_CNT) ? wcnt_q : {1'b0, wstat_q};
  assign busy_o      = (state_q != ST_IDLE);
  assign fetch_ok_o  = ok_q;
  assign fetch_nak_o = nak_q;
  assign wb_done_o   = wb_q;

  a_r3_disabled_no_fetch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_valid_i && !ep_en_i[req_ep_i]) |=> (fetch_nak_o && !mem_req_o));
  a_r4_nak_releases: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_nak_o |-> (!busy_o && !mem_we_o));
  a_r5_grant_owned: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_ok_o |-> buf_stat_o[OWN_BIT]);
  a_r6_cnt_before_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_we_o && mem_addr_o == base_addr) |->
      ($past(mem_we_o) && $past(mem_addr_o) == base_addr + ADDR_W'(1)));
  a_r6_release_clears_own: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_done_o |-> ($past(mem_we_o) && !$past(mem_wdata_o[OWN_BIT])));
  a_r7_busy_ignores_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_XFER && !xfer_done_i) |=> !(fetch_ok_o || fetch_nak_o || mem_req_o));
  a_r8_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_ok_o || fetch_nak_o || wb_done_o) |=> !(fetch_ok_o || fetch_nak_o || wb_done_o));
endmodule

// File: tb/bd_engine_test.sv
`timescale 1ns/1ps
module bd_engine_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] ep_en_i = '0;
  logic        req_valid_i = 1'b0;
  logic [3:0]  req_ep_i = '0;
  logic        req_dir_i = 1'b0;
  logic        busy_o, fetch_ok_o, fetch_nak_o, wb_done_o;
  logic [15:0] buf_addr_o;
  logic [7:0]  buf_cnt_o, buf_stat_o;
  logic        xfer_done_i = 1'b0;
  logic [7:0]  xfer_cnt_i = '0;
  logic [6:0]  xfer_stat_i = '0;
  logic        mem_req_o, mem_we_o;
  logic [15:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i = '0;

  int tests = 0;
  int fails = 0;
  bit ended = 0;

  always #2.5 clk_i = ~clk_i;

  bd_engine uut (.*);

  // RAM model with access logs
  logic [7:0]  ram [0:2047];
  logic [15:0] rlog_a [8];
  logic [15:0] wlog_a [8];
  logic [7:0]  wlog_d [8];
  int rd_tot = 0;
  int wr_tot = 0;

  always @(posedge clk_i) begin
    if (mem_req_o) begin
      if (mem_we_o) begin
        ram[mem_addr_o[10:0]] <= mem_wdata_o;
        wlog_a[wr_tot % 8] <= mem_addr_o;
        wlog_d[wr_tot % 8] <= mem_wdata_o;
        wr_tot <= wr_tot + 1;
      end else begin
        mem_rdata_i <= ram[mem_addr_o[10:0]];
        rlog_a[rd_tot % 8] <= mem_addr_o;
        rd_tot <= rd_tot + 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  function automatic int bd_base(input int ep, input int dir);
    return 'h400 + 4 * (2 * ep + dir);
  endfunction

  task automatic run_trial(input int ep, input int dir, input bit en, input bit own);
    int base, cyc, rd0, wr0, other;
    logic [7:0] st, cn, lo, hi, dcnt;
    logic [6:0] dst;
    base = bd_base(ep, dir);
    st = {own, 7'($urandom)};
    cn = 8'($urandom); lo = 8'($urandom); hi = 8'($urandom);
    ram[base[10:0]] = st; ram[base[10:0]+1] = cn;
    ram[base[10:0]+2] = lo; ram[base[10:0]+3] = hi;
    @(negedge clk_i);
    ep_en_i = 16'($urandom);
    ep_en_i[ep] = en;
    rd0 = rd_tot; wr0 = wr_tot;
    req_valid_i = 1'b1; req_ep_i = 4'(ep); req_dir_i = dir[0];
    @(negedge clk_i);
    req_valid_i = 1'b0;
    cyc = 1;
    while (!(fetch_ok_o || fetch_nak_o) && cyc < 20) begin
      @(negedge clk_i); cyc++;
    end
    if (!en) begin
      check(fetch_nak_o && !fetch_ok_o, "R3 nak on disabled", {fetch_ok_o, fetch_nak_o}, 1);
      check(cyc == 1, "R3 nak timing", cyc, 1);
      check(rd_tot == rd0 && wr_tot == wr0, "R3 no ram access", rd_tot - rd0 + wr_tot - wr0, 0);
    end else begin
      check(rd_tot - rd0 == 4, "R2 four reads", rd_tot - rd0, 4);
      for (int k = 0; k < 4; k++)
        check(rlog_a[(rd0 + k) % 8] == 16'(base + k), "R2 read address order",
              rlog_a[(rd0 + k) % 8], base + k);
      check(cyc == 6, "R4/R5 fetch latency", cyc, 6);
      if (!own) begin
        check(fetch_nak_o && !fetch_ok_o, "R4 nak on cpu-owned", {fetch_ok_o, fetch_nak_o}, 1);
      end else begin
        check(fetch_ok_o && !fetch_nak_o, "R5 grant on owned", {fetch_ok_o, fetch_nak_o}, 2);
        check(buf_addr_o == {hi, lo}, "R5 buffer address", buf_addr_o, {hi, lo});
        check(buf_cnt_o == cn, "R5 byte count", buf_cnt_o, cn);
        check(buf_stat_o == st, "R5 status byte", buf_stat_o, st);
      end
    end
    @(negedge clk_i);
    check(!fetch_ok_o && !fetch_nak_o, "R8 fetch result pulse", {fetch_ok_o, fetch_nak_o}, 0);
    if (!(en && own)) begin
      check(!busy_o, "R4 back to idle", busy_o, 0);
      check(wr_tot == wr0, "R4 no write", wr_tot - wr0, 0);
      check(ram[base[10:0]] == st, "R4 status untouched", ram[base[10:0]], st);
      return;
    end
    // R7: a request while busy must not start anything
    rd0 = rd_tot;
    other = (ep + 1) % 16;
    ep_en_i[other] = 1'b1;
    req_valid_i = 1'b1; req_ep_i = 4'(other); req_dir_i = 1'($urandom);
    repeat (2) @(negedge clk_i);
    req_valid_i = 1'b0;
    repeat (6) begin
      @(negedge clk_i);
      if (fetch_ok_o || fetch_nak_o)
        check(0, "R7 result while busy", 1, 0);
    end
    check(rd_tot == rd0, "R7 no reads while busy", rd_tot - rd0, 0);
    check(busy_o, "R7 still busy", busy_o, 1);
    dcnt = 8'($urandom); dst = 7'($urandom);
    xfer_done_i = 1'b1; xfer_cnt_i = dcnt; xfer_stat_i = dst;
    @(negedge clk_i);
    xfer_done_i = 1'b0;
    cyc = 0;
    while (!wb_done_o && cyc < 20) begin
      @(negedge clk_i); cyc++;
    end
    check(cyc == 2, "R6 write-back timing", cyc, 2);
    check(wr_tot - wr0 == 2, "R6 two writes", wr_tot - wr0, 2);
    check(wlog_a[wr0 % 8] == 16'(base + 1) && wlog_d[wr0 % 8] == dcnt,
          "R6 count written first", wlog_a[wr0 % 8], base + 1);
    check(wlog_a[(wr0 + 1) % 8] == 16'(base) && wlog_d[(wr0 + 1) % 8] == {1'b0, dst},
          "R6 status written second", wlog_d[(wr0 + 1) % 8], {1'b0, dst});
    check(ram[base[10:0]][7] == 1'b0, "R6 ownership released", ram[base[10:0]], {1'b0, dst});
    @(negedge clk_i);
    check(!wb_done_o && !busy_o, "R8 wb_done pulse", {wb_done_o, busy_o}, 0);
  endtask

  initial begin
    #(5.0 * 150000);
    if (!ended) begin
      fails++; tests++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    for (int i = 0; i < 2048; i++) ram[i] = 8'(i * 7);
    repeat (3) @(negedge clk_i);
    check(!busy_o && !fetch_ok_o && !fetch_nak_o && !wb_done_o && !mem_req_o,
          "R1 reset outputs", {busy_o, fetch_ok_o, fetch_nak_o, wb_done_o, mem_req_o}, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    check(!busy_o && !mem_req_o, "R1 idle after reset", {busy_o, mem_req_o}, 0);
    run_trial(0, 0, 1'b1, 1'b1);
    run_trial(15, 1, 1'b1, 1'b1);
    run_trial(3, 1, 1'b0, 1'b1);
    run_trial(7, 0, 1'b1, 1'b0);
    run_trial(0, 1, 1'b1, 1'b1);
    for (int t = 0; t < 60; t++)
      run_trial(int'($urandom_range(0, 15)), int'($urandom_range(0, 1)),
                1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 2) != 0));
    ended = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule